// File: doc/BRIEF.md
# Configuration Stream Loader

This block runs on the host side of a byte-wide register bus and walks a remote configuration engine through a complete load of a configuration file. After a start pulse, which carries the total file length, it asks for the shared data-buffer lock. Once the lock is granted it reads the engine's control register into a shadow copy. It then steps the control bits through a fixed setup order, with one write per step. Next it drains the file's comment header from the input stream and sends the rest to the engine's data port in whole-buffer bursts.

After each burst the loader reads the status register. An error flag there ends the load at once. When no buffers are left, the loader polls the status register until the done bit appears. If the done bit does not come within a programmable number of polls, the load ends with a timeout. Every ending takes the same path: the engine is parked in reset with start cleared, the lock request drops, and a one-cycle result pulse is raised.

File bytes enter on a valid/ready stream. The upstream source must hold `s_data_i` stable while `s_valid_i` is high and `s_ready_o` is low, and it must not make `s_valid_i` depend on `s_ready_o`. The loader raises `s_ready_o` only while it drains the header or fills a buffer slot with real file data, so it applies back-pressure at every other time. `s_ready_o` does not depend on `s_valid_i`.

Top module: `cfg_stream_loader`

## Requirements
- R1: `lock_req_o` rises in the cycle after an accepted start. No bus read or write is issued until `lock_gnt_i` is high. `lock_req_o` stays high until the result cycle, where it falls.
- R2: After the grant, the loader reads the control register (address 18h) once. It then makes four control writes, each derived from the previous value: set bit 7 (reset); set bit 3 (force mode) and clear bit 4 (mode); set bits 5 (start) and 6 (source select); clear bit 7. All other bits keep the value that was read.
- R3: The first HDR_BYTES (default 512) stream bytes, or the whole file if it is shorter, are accepted and never written to the device.
- R4: Body bytes are written in order to the data address 40h, one write per cycle, in bursts of exactly BUF_BYTES. The tail of the last burst is filled with 00h. A read and a write never share a cycle.
- R5: A stream byte is taken only when `s_valid_i` and `s_ready_o` are both high. During padding `s_ready_o` stays low. The number of bytes taken equals the header bytes plus the body bytes the loader actually sent.
- R6: After each burst the loader reads status (address 04h). Status bit 2 set means a configuration error: no further data is written and the result is an error with code 1. The same bit seen while polling for done, with bit 7 clear, also gives code 1.
- R7: Once all bursts are sent, the loader reads status at 04h repeatedly until bit 7 (done) is 1. It then finishes with success and code 0.
- R8: If POLL_LIMIT done-polls all read bit 7 as 0, the load ends as an error with code 2, after exactly POLL_LIMIT polls.
- R9: On every ending, the last bus access is a control write that has bit 7 set and bit 5 clear, with all other bits taken from the shadow copy.
- R10: Each load ends with exactly one one-cycle pulse, on `done_o` for success or on `err_o` otherwise. `err_code_o` and `status_o`, which holds the last status byte read, stay valid until the next start.
- R11: A file no longer than the header sends no data. The loader goes straight from the setup writes and header drain to done polling.
- R12: `start_i` and `total_len_i` are ignored while a load is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start pulse, accepted only when idle |
| total_len_i | input | LEN_W | File length in bytes, sampled with the start pulse |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Stream byte accepted when high together with valid |
| lock_req_o | output | 1 | Data-buffer lock request |
| lock_gnt_i | input | 1 | Data-buffer lock grant |
| bus_addr_o | output | 7 | Register bus byte address |
| bus_wdata_o | output | 8 | Register bus write data |
| bus_wr_o | output | 1 | Register bus write strobe |
| bus_rd_o | output | 1 | Register bus read strobe; read data is expected in the following cycle |
| bus_rdata_i | input | 8 | Register bus read data |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle failure pulse |
| err_code_o | output | 2 | 0 none, 1 configuration error, 2 poll timeout |
| status_o | output | 8 | Last status byte read |

## Verification
The bench sweeps the body length from zero up to past two and a half bursts, using a small buffer. This separates exact-fill bursts from padded tails and shows any off-by-one in the burst count. Each length is run with a different stall pattern on the stream, to show that the pace of the data does not change the data sent. Each length also uses a different starting control value, which shows whether the read-modify-write keeps untouched bits, and a different done-poll delay. Separate runs inject an error flag on the first burst, on a middle burst, and during polling, and one run never raises done. These runs separate the three ending codes and confirm that writing stops at the right byte count. A short file under the header length and a start pulse given mid-load cover the remaining corners.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  localparam int ADDR_W = 7;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h18;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 7'h04;
  localparam logic [ADDR_W-1:0] DATA_ADDR = 7'h40;

  // control register bit positions
  localparam int CB_RESET = 7;
  localparam int CB_SRC   = 6;
  localparam int CB_START = 5;
  localparam int CB_MODE  = 4;
  localparam int CB_FORCE = 3;

  // status register bit positions
  localparam int SB_DONE = 7;
  localparam int SB_ERR  = 2;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_CFG  = 2'd1,
    ERR_TMO  = 2'd2
  } err_code_e;

  typedef enum logic [1:0] {
    RK_CTRL = 2'd0,
    RK_BUF  = 2'd1,
    RK_POLL = 2'd2
  } rd_kind_e;

  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data;
  } bus_cmd_t;

  // one setup step applied to the shadow control value
  function automatic logic [7:0] setup_step(input logic [7:0] cur, input logic [1:0] step);
    logic [7:0] v;
    v = cur;
    case (step)
      2'd0: v[CB_RESET] = 1'b1;
      2'd1: begin
        v[CB_FORCE] = 1'b1;
        v[CB_MODE]  = 1'b0;
      end
      2'd2: begin
        v[CB_START] = 1'b1;
        v[CB_SRC]   = 1'b1;
      end
      default: v[CB_RESET] = 1'b0;
    endcase
    return v;
  endfunction

  function automatic logic [7:0] park_value(input logic [7:0] cur);
    logic [7:0] v;
    v = cur;
    v[CB_RESET] = 1'b1;
    v[CB_START] = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/cfgl_bus_port.sv
module cfgl_bus_port
  import cfgl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bus_cmd_t          cmd_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      bus_wr_o    <= 1'b0;
      bus_rd_o    <= 1'b0;
    end else begin
      bus_wr_o    <= cmd_i.wr;
      bus_rd_o    <= cmd_i.rd;
      bus_addr_o  <= (cmd_i.wr || cmd_i.rd) ? cmd_i.addr : '0;
      bus_wdata_o <= cmd_i.wr ? cmd_i.data : '0;
    end
  end

  // R4
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_o && bus_rd_o));

endmodule

// File: rtl/cfgl_byte_feeder.sv
module cfgl_byte_feeder #(
  parameter int LEN_W     = 24,
  parameter int HDR_BYTES = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] total_i,
  input  logic             hdr_en_i,
  input  logic             buf_en_i,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  output logic             s_ready_o,
  output logic             hdr_done_o,
  output logic             byte_valid_o,
  output logic [7:0]       byte_o,
  output logic [LEN_W-1:0] body_len_o
);

  localparam logic [LEN_W-1:0] HDR_LEN = LEN_W'(HDR_BYTES);

  logic [LEN_W-1:0] hdr_left_q;
  logic [LEN_W-1:0] body_left_q;
  logic [LEN_W-1:0] hdr_len_w;
  logic             pad_w;
  logic             take_w;

  assign hdr_len_w  = (total_i > HDR_LEN) ? HDR_LEN : total_i;
  assign body_len_o = total_i - hdr_len_w;

  assign pad_w        = (body_left_q == '0);
  assign hdr_done_o   = (hdr_left_q == '0);
  assign s_ready_o    = (hdr_en_i && !hdr_done_o) || (buf_en_i && !pad_w);
  assign take_w       = s_valid_i && s_ready_o;
  assign byte_valid_o = pad_w || s_valid_i;
  assign byte_o       = pad_w ? 8'h00 : s_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_left_q  <= '0;
      body_left_q <= '0;
    end else if (load_i) begin
      hdr_left_q  <= hdr_len_w;
      body_left_q <= body_len_o;
    end else if (take_w) begin
      if (!hdr_done_o) hdr_left_q  <= hdr_left_q - 1'b1;
      else             body_left_q <= body_left_q - 1'b1;
    end
  end

  // R3
  hdr_before_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_left_q != '0) |-> !buf_en_i);

  // R5
  pad_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en_i && pad_w) |-> !s_ready_o);

endmodule

// File: rtl/cfgl_poll_timer.sv
module cfgl_poll_timer #(
  parameter int POLL_LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic last_o
);

  localparam int CW = $clog2(POLL_LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(POLL_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (tick_i && !last_o) cnt_q <= cnt_q + 1'b1;
  end

  // R8
  tmo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(POLL_LIMIT));

endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfgl_pkg::*;
#(
  parameter int BUF_BYTES  = 32,
  parameter int HDR_BYTES  = 512,
  parameter int LEN_W      = 24,
  parameter int POLL_LIMIT = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] total_len_i,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  output logic             s_ready_o,
  output logic             lock_req_o,
  input  logic             lock_gnt_i,
  output logic [6:0]       bus_addr_o,
  output logic [7:0]       bus_wdata_o,
  output logic             bus_wr_o,
  output logic             bus_rd_o,
  input  logic [7:0]       bus_rdata_i,
  output logic             done_o,
  output logic             err_o,
  output logic [1:0]       err_code_o,
  output logic [7:0]       status_o
);

  // BUF_BYTES must be a power of two, at least 2
  localparam int SLOT_W = $clog2(BUF_BYTES);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(BUF_BYTES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_LOCK, S_RD, S_RW1, S_RW2, S_WCTL,
    S_HDR, S_BUF, S_PARK, S_FLUSH, S_EXIT
  } state_e;

  state_e           state_q;
  rd_kind_e         kind_q;
  err_code_e        code_q;
  logic [7:0]       shadow_q;
  logic [7:0]       status_q;
  logic [1:0]       step_q;
  logic [SLOT_W-1:0] slot_q;
  logic [LEN_W-1:0] buf_left_q;

  logic             load_w;
  logic             hdr_done_w;
  logic             feed_valid_w;
  logic [7:0]       feed_byte_w;
  logic [LEN_W-1:0] body_len_w;
  logic [LEN_W:0]   body_up_w;
  logic [LEN_W-1:0] nbuf_w;
  logic             tmo_last_w;
  bus_cmd_t         cmd_w;

  assign load_w    = (state_q == S_IDLE) && start_i;
  assign body_up_w = {1'b0, body_len_w} + (LEN_W+1)'(BUF_BYTES - 1);
  assign nbuf_w    = LEN_W'(body_up_w >> SLOT_W);

  cfgl_byte_feeder #(
    .LEN_W    (LEN_W),
    .HDR_BYTES(HDR_BYTES)
  ) feeder_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_w),
    .total_i     (total_len_i),
    .hdr_en_i    (state_q == S_HDR),
    .buf_en_i    (state_q == S_BUF),
    .s_valid_i   (s_valid_i),
    .s_data_i    (s_data_i),
    .s_ready_o   (s_ready_o),
    .hdr_done_o  (hdr_done_w),
    .byte_valid_o(feed_valid_w),
    .byte_o      (feed_byte_w),
    .body_len_o  (body_len_w)
  );

  cfgl_poll_timer #(
    .POLL_LIMIT(POLL_LIMIT)
  ) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (state_q == S_IDLE),
    .tick_i((state_q == S_RW2) && (kind_q == RK_POLL)),
    .last_o(tmo_last_w)
  );

  // bus command for the current state
  always_comb begin
    cmd_w = '0;
    case (state_q)
      S_RD: begin
        cmd_w.rd   = 1'b1;
        cmd_w.addr = (kind_q == RK_CTRL) ? CTRL_ADDR : STAT_ADDR;
      end
      S_WCTL: begin
        cmd_w.wr   = 1'b1;
        cmd_w.addr = CTRL_ADDR;
        cmd_w.data = setup_step(shadow_q, step_q);
      end
      S_BUF: begin
        cmd_w.wr   = feed_valid_w;
        cmd_w.addr = DATA_ADDR;
        cmd_w.data = feed_byte_w;
      end
      S_PARK: begin
        cmd_w.wr   = 1'b1;
        cmd_w.addr = CTRL_ADDR;
        cmd_w.data = park_value(shadow_q);
      end
      default: cmd_w = '0;
    endcase
  end

  cfgl_bus_port port_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd_w),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_wr_o   (bus_wr_o),
    .bus_rd_o   (bus_rd_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      kind_q     <= RK_CTRL;
      code_q     <= ERR_NONE;
      shadow_q   <= '0;
      status_q   <= '0;
      step_q     <= '0;
      slot_q     <= '0;
      buf_left_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          buf_left_q <= nbuf_w;
          code_q     <= ERR_NONE;
          status_q   <= '0;
          state_q    <= S_LOCK;
        end
        S_LOCK: if (lock_gnt_i) begin
          kind_q  <= RK_CTRL;
          state_q <= S_RD;
        end
        S_RD:  state_q <= S_RW1;
        S_RW1: state_q <= S_RW2;
        S_RW2: begin
          case (kind_q)
            RK_CTRL: begin
              shadow_q <= bus_rdata_i;
              step_q   <= '0;
              state_q  <= S_WCTL;
            end
            RK_BUF: begin
              status_q <= bus_rdata_i;
              if (bus_rdata_i[SB_ERR]) begin
                code_q  <= ERR_CFG;
                state_q <= S_PARK;
              end else if (buf_left_q == '0) begin
                kind_q  <= RK_POLL;
                state_q <= S_RD;
              end else begin
                slot_q  <= '0;
                state_q <= S_BUF;
              end
            end
            default: begin
              status_q <= bus_rdata_i;
              if (bus_rdata_i[SB_DONE]) begin
                state_q <= S_PARK;
              end else if (bus_rdata_i[SB_ERR]) begin
                code_q  <= ERR_CFG;
                state_q <= S_PARK;
              end else if (tmo_last_w) begin
                code_q  <= ERR_TMO;
                state_q <= S_PARK;
              end else begin
                state_q <= S_RD;
              end
            end
          endcase
        end
        S_WCTL: begin
          shadow_q <= cmd_w.data;
          if (step_q == 2'd3) state_q <= S_HDR;
          else                step_q  <= step_q + 1'b1;
        end
        S_HDR: if (hdr_done_w) begin
          if (buf_left_q == '0) begin
            kind_q  <= RK_POLL;
            state_q <= S_RD;
          end else begin
            slot_q  <= '0;
            state_q <= S_BUF;
          end
        end
        S_BUF: if (feed_valid_w) begin
          if (slot_q == SLOT_LAST) begin
            buf_left_q <= buf_left_q - 1'b1;
            kind_q     <= RK_BUF;
            state_q    <= S_RD;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        S_PARK: begin
          shadow_q <= cmd_w.data;
          state_q  <= S_FLUSH;
        end
        S_FLUSH: state_q <= S_EXIT;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign lock_req_o = (state_q != S_IDLE) && (state_q != S_EXIT);
  assign done_o     = (state_q == S_EXIT) && (code_q == ERR_NONE);
  assign err_o      = (state_q == S_EXIT) && (code_q != ERR_NONE);
  assign err_code_o = code_q;
  assign status_o   = status_q;

  // R1
  bus_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_o || bus_rd_o) |-> lock_req_o);

  // R1
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_req_o) |-> (done_o || err_o));

  // R9
  park_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> ($past(bus_wr_o) && ($past(bus_addr_o) == CTRL_ADDR)
                           && $past(bus_wdata_o[CB_RESET]) && !$past(bus_wdata_o[CB_START])));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |=> !(done_o || err_o));

endmodule

// File: tb/cfg_stream_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_stream_loader_tb_top;

  localparam int BUF  = 8;
  localparam int HDR  = 512;
  localparam int LW   = 16;
  localparam int PLIM = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [LW-1:0] total_len_i = '0;
  logic          s_valid_i = 1'b0;
  logic [7:0]    s_data_i = '0;
  logic          s_ready_o;
  logic          lock_req_o;
  logic          lock_gnt_i = 1'b0;
  logic [6:0]    bus_addr_o;
  logic [7:0]    bus_wdata_o;
  logic          bus_wr_o;
  logic          bus_rd_o;
  logic [7:0]    bus_rdata_i;
  logic          done_o;
  logic          err_o;
  logic [1:0]    err_code_o;
  logic [7:0]    status_o;

  always #2.5 clk = ~clk;

  cfg_stream_loader #(
    .BUF_BYTES(BUF), .HDR_BYTES(HDR), .LEN_W(LW), .POLL_LIMIT(PLIM)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .total_len_i(total_len_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
    .lock_req_o(lock_req_o), .lock_gnt_i(lock_gnt_i),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_wr_o(bus_wr_o),
    .bus_rd_o(bus_rd_o), .bus_rdata_i(bus_rdata_i), .done_o(done_o), .err_o(err_o),
    .err_code_o(err_code_o), .status_o(status_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // device model state
  logic       clr = 1'b0;
  logic [7:0] init_v = '0;
  int         err_idx = -1;
  int         done_at = 0;
  logic [7:0] ctl_reg;
  logic [7:0] ctl_log [0:15];
  logic [7:0] data_log [0:63];
  int ctl_n, data_n, st_reads, acc_n, pre_gnt, done_cyc, err_cyc, other_wr;

  function automatic logic [7:0] fbyte(input int i);
    return 8'((i * 7) + ((i >> 8) * 13) + 5);
  endfunction

  function automatic logic [7:0] stat_val(input int k);
    if (k == err_idx) return 8'h04;
    if (k >= done_at) return 8'h80;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (clr) begin
      ctl_reg <= init_v; ctl_n <= 0; data_n <= 0; st_reads <= 0; acc_n <= 0;
      pre_gnt <= 0; done_cyc <= 0; err_cyc <= 0; other_wr <= 0; bus_rdata_i <= '0;
    end else begin
      if (bus_wr_o) begin
        if (bus_addr_o == 7'h18) begin
          ctl_reg <= bus_wdata_o;
          if (ctl_n < 16) ctl_log[ctl_n] <= bus_wdata_o;
          ctl_n <= ctl_n + 1;
        end else if (bus_addr_o == 7'h40) begin
          if (data_n < 64) data_log[data_n] <= bus_wdata_o;
          data_n <= data_n + 1;
        end else other_wr <= other_wr + 1;
      end
      if (bus_rd_o) begin
        if (bus_addr_o == 7'h18) bus_rdata_i <= ctl_reg;
        else if (bus_addr_o == 7'h04) begin
          bus_rdata_i <= stat_val(st_reads);
          st_reads <= st_reads + 1;
        end
      end
      if ((bus_wr_o || bus_rd_o) && !lock_gnt_i) pre_gnt <= pre_gnt + 1;
      if (s_valid_i && s_ready_o) acc_n <= acc_n + 1;
      if (done_o) done_cyc <= done_cyc + 1;
      if (err_o)  err_cyc <= err_cyc + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive_stream(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && (i % gap) == 0) begin
        s_valid_i = 1'b0;
        @(negedge clk);
      end
      s_valid_i = 1'b1;
      s_data_i  = fbyte(i);
      while (!s_ready_o) @(negedge clk);
      @(negedge clk);
    end
    s_valid_i = 1'b0;
  endtask

  task automatic drive_grant();
    repeat (3) @(negedge clk);
    lock_gnt_i = 1'b1;
  endtask

  task automatic late_start();
    repeat (30) @(negedge clk);
    start_i = 1'b1; total_len_i = LW'(7);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // dd < 0: done never appears; eix < 0: no error flag
  task automatic run(input int total, input int gap, input logic [7:0] ictl,
                     input int dd, input int eix, input bit restart);
    int body, nbuf, bytes, reads, code, last, hdr_t, cons, cyc, bad;
    logic [7:0] s1, s2, s3, s4, s5;
    body = (total > HDR) ? total - HDR : 0;
    hdr_t = (total > HDR) ? HDR : total;
    nbuf = (body + BUF - 1) / BUF;
    err_idx = eix;
    done_at = (dd < 0) ? 32'h7fff_ffff : nbuf + dd;
    init_v = ictl;
    bytes = nbuf * BUF;
    if (eix >= 0 && eix < nbuf) begin
      code = 1; reads = eix + 1; bytes = (eix + 1) * BUF; last = 8'h04;
    end else if (dd < 0) begin
      code = 2; reads = nbuf + PLIM; last = 8'h00;
    end else if (eix >= nbuf && eix < done_at) begin
      code = 1; reads = eix + 1; last = 8'h04;
    end else begin
      code = 0; reads = done_at + 1; last = 8'h80;
    end
    cons = hdr_t + ((body < bytes) ? body : bytes);
    s1 = ictl | 8'h80;
    s2 = (s1 | 8'h08) & 8'hEF;
    s3 = s2 | 8'h60;
    s4 = s3 & 8'h7F;
    s5 = (s4 | 8'h80) & 8'hDF;

    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    total_len_i = LW'(total); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R1", "lock request after start", int'(lock_req_o), 1);
    fork
      drive_stream(total, gap);
      drive_grant();
      if (restart) late_start();
    join_none
    cyc = 0;
    while (!(done_o || err_o) && cyc < 20000) begin
      @(negedge clk); cyc++;
    end
    repeat (3) @(negedge clk);
    disable fork;
    s_valid_i = 1'b0; lock_gnt_i = 1'b0; start_i = 1'b0;

    chk("R10", "success pulses", done_cyc, (code == 0) ? 1 : 0);
    chk("R10", "failure pulses", err_cyc, (code != 0) ? 1 : 0);
    chk((code == 2) ? "R8" : (code == 1) ? "R6" : "R7", "result code", int'(err_code_o), code);
    chk("R10", "last status", int'(status_o), last);
    chk("R7", "status reads", st_reads, reads);
    chk("R4", "data bytes written", data_n, bytes);
    bad = 0;
    for (int j = 0; j < data_n && j < 64; j++)
      if (data_log[j] != ((j < body) ? fbyte(HDR + j) : 8'h00)) bad++;
    chk("R3", "data content mismatches", bad, 0);
    chk("R5", "stream bytes taken", acc_n, cons);
    chk("R2", "control writes", ctl_n, 5);
    chk("R2", "setup write 1", int'(ctl_log[0]), int'(s1));
    chk("R2", "setup write 2", int'(ctl_log[1]), int'(s2));
    chk("R2", "setup write 3", int'(ctl_log[2]), int'(s3));
    chk("R2", "setup write 4", int'(ctl_log[3]), int'(s4));
    chk("R9", "park write", int'(ctl_log[4]), int'(s5));
    chk("R1", "accesses before grant", pre_gnt, 0);
    chk("R1", "lock released", int'(lock_req_o), 0);
    chk("R4", "writes to other addresses", other_wr, 0);
    if (restart) chk("R12", "bytes taken with start while busy", acc_n, cons);
    if (nbuf == 0) chk("R11", "no data for header-only file", data_n, 0);
  endtask

  initial begin
    #(150000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset lock request", int'(lock_req_o), 0);
    chk("R10", "reset result pulses", int'(done_o | err_o), 0);
    chk("R4", "reset bus strobes", int'(bus_wr_o | bus_rd_o), 0);
    chk("R5", "reset stream ready", int'(s_ready_o), 0);

    for (int b = 0; b <= 20; b++)
      run(HDR + b, b % 4, 8'((b * 29) & 8'h57), b % 3, -1, b == 5);
    run(100, 2, 8'h11, 1, -1, 1'b0);        // R11
    run(0, 0, 8'hFF, 0, -1, 1'b0);          // R11
    run(HDR + 20, 1, 8'h00, 0, 1, 1'b0);    // R6 middle burst
    run(HDR + 3, 0, 8'h42, 0, 0, 1'b0);     // R6 first burst
    run(HDR + 9, 3, 8'h18, 3, 3, 1'b0);     // R6 during polling
    run(HDR + 16, 2, 8'h03, -1, -1, 1'b0);  // R8
    run(HDR, 0, 8'h9C, -1, -1, 1'b0);       // R8 with no body

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule